// File: doc/BRIEF.md
# Serial 1101 Sequence Detector

This block watches a single-bit serial stream that is sampled on every rising clock edge and flags each place where the four most recent bits, oldest first, read 1, 1, 0, 1. Matches may overlap, so the trailing 1 of one match can begin the next one.

Two detectors run side by side on the same stream, so that their timing can be compared directly:
- The state-only (Moore) detector raises its flag in the cycle after the final 1 has been sampled.
- The state-plus-input (Mealy) detector raises its flag combinationally, in the same cycle that the final 1 is present on the input.

An active-high asynchronous reset returns both machines to their idle state. Any state encoding that is not legal also falls back to idle on the next edge.

State-only machine, states and transitions (input 1 / input 0):
- MR_IDLE: MR_ONE / MR_IDLE
- MR_ONE: MR_ONE_ONE / MR_IDLE
- MR_ONE_ONE: MR_ONE_ONE / MR_ONE_ONE_ZERO
- MR_ONE_ONE_ZERO: MR_HIT / MR_IDLE
- MR_HIT: MR_ONE_ONE / MR_IDLE

Only MR_HIT drives the flag high.

State-plus-input machine, states and transitions (input 1 / input 0):
- ML_IDLE (00): ML_ONE / ML_IDLE
- ML_ONE (01): ML_ONE_ONE / ML_IDLE
- ML_ONE_ONE (10): ML_ONE_ONE / ML_ONE_ONE_ZERO
- ML_ONE_ONE_ZERO (11): ML_ONE / ML_IDLE

The flag is high exactly when the state is ML_ONE_ONE_ZERO and the input is 1.

Top module: `seq1101_dual_detect`

## Requirements
- R1: While `arst` is high, both `hit_moore` and `hit_mealy` are 0, whatever the value of `serial_in`. Asserting `arst` between clock edges clears any partial match at once.
- R2: `hit_mealy` is 1 in a cycle exactly when the three bits sampled at the last three edges were 1, 1, 0 (oldest first) and `serial_in` is 1 now.
- R3: `hit_moore` is 1 in a cycle exactly when the four bits sampled at the last four edges were 1, 1, 0, 1 (oldest first). It therefore equals the value `hit_mealy` had in the previous cycle.
- R4: Overlapping matches are reported. On the stream 1101101 (first bit first), `hit_mealy` pulses while the 4th and the 7th bits are present, and `hit_moore` pulses one cycle after each of those.
- R5: `hit_moore` is never high in two consecutive cycles.
- R6: After a match whose final bit is 1, the state-plus-input machine continues from the state meaning "one 1 seen". Any number of consecutive 1s leaves the detectors waiting for a 0 followed by a 1.
- R7: A 0 on `serial_in` forces `hit_mealy` to 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; `serial_in` is sampled on its rising edge |
| arst | input | 1 | Asynchronous reset, active high; both machines go idle |
| serial_in | input | 1 | Serial data bit |
| hit_moore | output | 1 | Match flag from the state-only machine, one cycle after the final 1 |
| hit_mealy | output | 1 | Match flag from the state-plus-input machine, in the cycle of the final 1 |

## Verification
The hardest situations to reach from the ports are the overlaps: a match whose final 1 must also serve as the first 1 of the next match, and a long run of 1s that has to park the machines without reporting anything. The bench drives these as directed streams (1101101 and 1111101). It then runs a few thousand random bits biased towards 1, which reach these states often, and compares both flags against a four-bit shift-register model. A reset asserted between clock edges in the middle of a partial match checks that the asynchronous clear discards the history.

// File: rtl/seq1101_pkg.sv
package seq1101_pkg;

    // State-only detector: five states, binary coded
    typedef enum logic [2:0] {
        MR_IDLE         = 3'd0,
        MR_ONE          = 3'd1,
        MR_ONE_ONE      = 3'd2,
        MR_ONE_ONE_ZERO = 3'd3,
        MR_HIT          = 3'd4
    } moore_st_t;

    // State-plus-input detector: four states, codes 00..11
    typedef enum logic [1:0] {
        ML_IDLE         = 2'b00,
        ML_ONE          = 2'b01,
        ML_ONE_ONE      = 2'b10,
        ML_ONE_ONE_ZERO = 2'b11
    } mealy_st_t;

endpackage

// File: rtl/seq1101_moore.sv
module seq1101_moore
    import seq1101_pkg::*;
(
    input  logic clk,
    input  logic arst,
    input  logic serial_in,
    output logic hit
);

    moore_st_t state_q;
    moore_st_t state_d;

    // Next-state logic
    always_comb begin
        state_d = MR_IDLE;
        unique case (state_q)
            MR_IDLE:         state_d = serial_in ? MR_ONE     : MR_IDLE;
            MR_ONE:          state_d = serial_in ? MR_ONE_ONE : MR_IDLE;
            MR_ONE_ONE:      state_d = serial_in ? MR_ONE_ONE : MR_ONE_ONE_ZERO;
            MR_ONE_ONE_ZERO: state_d = serial_in ? MR_HIT     : MR_IDLE;
            MR_HIT:          state_d = serial_in ? MR_ONE_ONE : MR_IDLE;
            default:         state_d = MR_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or posedge arst) begin
        if (arst) state_q <= MR_IDLE;
        else      state_q <= state_d;
    end

    // Output process: depends on state only
    always_comb begin
        unique case (state_q)
            MR_HIT:  hit = 1'b1;
            default: hit = 1'b0;
        endcase
    end

    // R5: a hit is always followed by at least one quiet cycle
    a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (arst)
        hit |=> !hit);

    // R3: a hit is only reported after a 1 was sampled
    a_r3_last_bit_one: assert property (@(posedge clk) disable iff (arst)
        hit |-> $past(serial_in));

endmodule

// File: rtl/seq1101_mealy.sv
module seq1101_mealy
    import seq1101_pkg::*;
(
    input  logic clk,
    input  logic arst,
    input  logic serial_in,
    output logic hit
);

    mealy_st_t state_q;
    mealy_st_t state_d;

    // Next-state logic
    always_comb begin
        state_d = ML_IDLE;
        unique case (state_q)
            ML_IDLE:         state_d = serial_in ? ML_ONE     : ML_IDLE;
            ML_ONE:          state_d = serial_in ? ML_ONE_ONE : ML_IDLE;
            ML_ONE_ONE:      state_d = serial_in ? ML_ONE_ONE : ML_ONE_ONE_ZERO;
            ML_ONE_ONE_ZERO: state_d = serial_in ? ML_ONE     : ML_IDLE;
            default:         state_d = ML_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or posedge arst) begin
        if (arst) state_q <= ML_IDLE;
        else      state_q <= state_d;
    end

    // Output process: depends on state and the present input
    always_comb begin
        unique case (state_q)
            ML_ONE_ONE_ZERO: hit = serial_in;
            default:         hit = 1'b0;
        endcase
    end

    // R7: a 0 on the input never produces a hit
    a_r7_zero_blocks_hit: assert property (@(posedge clk) disable iff (arst)
        !serial_in |-> !hit);

    // R6: a hit continues from the "one 1 seen" state
    a_r6_restart_after_hit: assert property (@(posedge clk) disable iff (arst)
        hit |=> (state_q == ML_ONE));

endmodule

// File: rtl/seq1101_dual_detect.sv
module seq1101_dual_detect (
    input  logic clk,
    input  logic arst,
    input  logic serial_in,
    output logic hit_moore,
    output logic hit_mealy
);

    seq1101_moore u_moore (
        .clk       (clk),
        .arst      (arst),
        .serial_in (serial_in),
        .hit       (hit_moore)
    );

    seq1101_mealy u_mealy (
        .clk       (clk),
        .arst      (arst),
        .serial_in (serial_in),
        .hit       (hit_mealy)
    );

    // R1: both flags are quiet while reset is held
    a_r1_reset_quiet: assert property (@(posedge clk)
        arst |-> (!hit_moore && !hit_mealy));

    // R3: the state-only flag trails the state-plus-input flag by one cycle
    a_r3_one_cycle_lag: assert property (@(posedge clk) disable iff (arst)
        hit_moore == $past(hit_mealy));

endmodule

// File: tb/seq1101_dual_detect_tb.sv
`timescale 1ns/1ps
module seq1101_dual_detect_tb;

    logic clk = 1'b0;
    logic arst;
    logic serial_in;
    logic hit_moore;
    logic hit_mealy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [3:0] hist = 4'b0000;   // last four sampled bits, newest in bit 0

    always #2 clk = ~clk;         // 4 ns period

    seq1101_dual_detect u_dut (
        .clk       (clk),
        .arst      (arst),
        .serial_in (serial_in),
        .hit_moore (hit_moore),
        .hit_mealy (hit_mealy)
    );

    function automatic logic exp_mealy(logic [3:0] h, logic b);
        return ({h[2:0], b} == 4'b1101);
    endfunction

    function automatic logic exp_moore(logic [3:0] h);
        return (h == 4'b1101);
    endfunction

    task automatic check(string req, string what, logic got, logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, got, exp);
        end
    endtask

    // Drive one bit in the low phase, check both flags, let it be sampled
    task automatic send(logic b, string req_mealy, string req_moore);
        @(negedge clk);
        serial_in = b;
        #1;
        check(req_mealy, "hit_mealy", hit_mealy, exp_mealy(hist, b));
        check(req_moore, "hit_moore", hit_moore, exp_moore(hist));
        @(posedge clk);
        hist = {hist[2:0], b};
    endtask

    task automatic send_stream(logic [31:0] bits, int n, string rm, string ro);
        for (int i = n - 1; i >= 0; i--) send(bits[i], rm, ro);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        failures++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        arst = 1'b1;
        serial_in = 1'b1;
        #9;
        // R1: quiet in reset even with a 1 on the input
        check("R1", "hit_mealy in reset", hit_mealy, 1'b0);
        check("R1", "hit_moore in reset", hit_moore, 1'b0);
        @(negedge clk);
        arst = 1'b0;
        hist = 4'b0000;

        // R4: overlapping 1101101
        send(1, "R4", "R4"); send(1, "R4", "R4"); send(0, "R4", "R4");
        @(negedge clk); serial_in = 1'b1; #1;
        check("R4", "hit_mealy at bit 4", hit_mealy, 1'b1);
        check("R4", "hit_moore at bit 4", hit_moore, 1'b0);
        @(posedge clk); hist = {hist[2:0], 1'b1};
        send(1, "R4", "R4");
        send(0, "R4", "R4");
        @(negedge clk); serial_in = 1'b1; #1;
        check("R4", "hit_mealy at bit 7", hit_mealy, 1'b1);
        @(posedge clk); hist = {hist[2:0], 1'b1};
        @(negedge clk); serial_in = 1'b0; #1;
        check("R4", "hit_moore after bit 7", hit_moore, 1'b1);
        check("R7", "hit_mealy with input 0", hit_mealy, 1'b0);
        @(posedge clk); hist = {hist[2:0], 1'b0};
        // R5: the flag drops in the next cycle
        send(0, "R7", "R5");

        // R6: long run of ones, then 0 and 1
        send_stream(32'b1111101, 7, "R6", "R6");
        send(1, "R6", "R3");
        send_stream(32'b01, 2, "R6", "R6");
        send(0, "R7", "R3");

        // R1: asynchronous reset between edges, mid-pattern
        send_stream(32'b110, 3, "R2", "R3");
        @(negedge clk);
        serial_in = 1'b1;
        #0.5;
        arst = 1'b1;
        #0.5;
        check("R1", "hit_mealy after async clear", hit_mealy, 1'b0);
        check("R1", "hit_moore after async clear", hit_moore, 1'b0);
        @(posedge clk);
        #1;
        arst = 1'b0;
        hist = 4'b0000;
        send(1, "R1", "R1");     // pattern must restart from nothing

        // Random stream biased towards 1
        void'($urandom(32'd1101));
        for (int k = 0; k < 3000; k++) begin
            logic b;
            b = ($urandom_range(0, 9) < 6);
            send(b, b ? "R2" : "R7", "R3");
        end

        finish_run();
    end

endmodule